// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block connects a clocked system to an external asynchronous static RAM with 64K locations of 4 bits. A client makes a single read or write with a valid/ready handshake. The controller then runs the memory's active-low select, write and output strobes through a fixed sequence of phases. Each phase lasts a whole number of clock cycles. That number comes from the parameterised nanosecond limits of the memory and the clock period: ceil(limit / period), and never less than one cycle.

Writes are timed by the write strobe, and output enable stays high for the whole write. Because of this the plain minimum write pulse applies, and the longer pulse that would also have to cover the memory's output turn-off time is not needed. The write pulse lasts as long as the longer of the pulse-width limit and the data-setup limit. The data bus has separate input, output and driver-enable ports, and the chip-level pad forms the tri-state bus from them. The driver is on only while the write strobe is low. After every read there is a turnaround wait sized from the output turn-off time, so the controller never drives the bus while the memory may still be driving it. A read returns its data with a one-cycle valid strobe.

Top module: `sram_ctl`

## Requirements
- R1: In reset and whenever idle, chip select, write enable and output enable are all high (memory in standby), the data driver is off, req_ready is high and rsp_valid is low.
- R2: During a write, write enable is low for exactly max(ceil(T_WP_NS/CLK_NS), ceil(T_DW_NS/CLK_NS)) consecutive cycles, each term at least 1.
- R3: During a write, chip select is low with write enable high for ceil(T_AS_NS/CLK_NS) cycles (minimum 1) before write enable falls. Chip select stays low for ceil(T_WR_NS/CLK_NS) cycles (minimum 1) after write enable rises.
- R4: Output enable stays high for the whole of every write.
- R5: The data driver enable is high exactly in the cycles where write enable is low, and in those cycles the driven data equals the accepted write data.
- R6: During a read, chip select and output enable are low and write enable is high for exactly ceil(T_AA_NS/CLK_NS) cycles (minimum 1).
- R7: rsp_valid is a one-cycle pulse in the cycle right after the last access cycle. rsp_rdata carries the bus value sampled at the end of that last access cycle.
- R8: After output enable rises at the end of a read, the data driver stays off for at least ceil(T_OHZ_NS/CLK_NS) cycles (minimum 1), and req_ready stays low during that wait.
- R9: A request is taken only on a cycle with req_valid and req_ready both high. Requests presented while req_ready is low are ignored. The memory address and the driven data stay those of the accepted request for as long as chip select is low.
- R10: req_ready is low for exactly the sum of the write phases after a write is accepted, and for the access plus turnaround cycles after a read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (16) | Word address |
| req_wdata | input | DATA_W (4) | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W (4) | Read data |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_addr | output | ADDR_W (16) | Memory address bus |
| sram_dq_out | output | DATA_W (4) | Data toward the memory |
| sram_dq_oe | output | 1 | Driver enable for sram_dq_out |
| sram_dq_in | input | DATA_W (4) | Data bus value as seen at the pad |

## Verification
The bench builds the controller with ADDR_W set to 5, so that every one of the 32 locations is written and then read back, with some requests held during busy periods. The timing is the default: a 4 ns clock with 12 ns access, 9 ns pulse, 6 ns data setup and 6 ns turn-off limits, and zero address setup and recovery. These values give phases of 3, 3, 2 and 2 cycles, and the zero limits fall back to the one-cycle minimum. The bench's memory model returns corrupted data until the access-time count has elapsed. This exposes an early capture, a wrongly rounded phase and any overlap between the two bus drivers.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_WSU  = 3'd1,  // select asserted, address settling before the strobe
    PH_WPL  = 3'd2,  // write strobe low, data driven
    PH_WRC  = 3'd3,  // strobe released, select still low
    PH_RAC  = 3'd4,  // read access wait
    PH_RTA  = 3'd5   // bus turnaround after a read
  } phase_e;

  // whole cycles covering a nanosecond limit, never below one
  function automatic int unsigned phase_cycles(input int unsigned lim_ns,
                                               input int unsigned clk_ns);
    int unsigned c;
    c = (lim_ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_rstsync.sv
module sram_ctl_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = ld || (cnt_q != '0);
    cnt_d  = ld ? ld_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CNT_W  = 2,
  parameter int unsigned AS_CYC = 1,
  parameter int unsigned WP_CYC = 3,
  parameter int unsigned WR_CYC = 1,
  parameter int unsigned AA_CYC = 3,
  parameter int unsigned TA_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             zero,
  output logic             ld,
  output logic [CNT_W-1:0] ld_val,
  output logic             accept,
  output logic             capture,
  output logic             ready,
  output logic             cs_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe
);
  localparam logic [CNT_W-1:0] AS_LD = CNT_W'(AS_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LD = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] AA_LD = CNT_W'(AA_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LD = CNT_W'(TA_CYC - 1);

  phase_e phase_q, phase_d;
  logic   cs_n_q, we_n_q, oe_n_q, dq_oe_q;
  logic   cs_n_d, we_n_d, oe_n_d, dq_oe_d;

  assign ready  = (phase_q == PH_IDLE);
  assign accept = ready && req_valid;

  // next phase and timer load
  always_comb begin
    phase_d = phase_q;
    ld      = 1'b0;
    ld_val  = '0;
    capture = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (req_valid) begin
        ld = 1'b1;
        if (req_write) begin phase_d = PH_WSU; ld_val = AS_LD; end
        else           begin phase_d = PH_RAC; ld_val = AA_LD; end
      end
      PH_WSU:  if (zero) begin phase_d = PH_WPL; ld = 1'b1; ld_val = WP_LD; end
      PH_WPL:  if (zero) begin phase_d = PH_WRC; ld = 1'b1; ld_val = WR_LD; end
      PH_WRC:  if (zero) phase_d = PH_IDLE;
      PH_RAC:  if (zero) begin
        phase_d = PH_RTA; ld = 1'b1; ld_val = TA_LD; capture = 1'b1;
      end
      PH_RTA:  if (zero) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  // strobes registered from the next phase so they switch with the state
  always_comb begin
    cs_n_d  = !(phase_d inside {PH_WSU, PH_WPL, PH_WRC, PH_RAC});
    we_n_d  = (phase_d != PH_WPL);
    oe_n_d  = (phase_d != PH_RAC);
    dq_oe_d = (phase_d == PH_WPL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cs_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cs_n_q  <= cs_n_d;
      we_n_q  <= we_n_d;
      oe_n_q  <= oe_n_d;
      dq_oe_q <= dq_oe_d;
    end
  end

  assign cs_n  = cs_n_q;
  assign we_n  = we_n_q;
  assign oe_n  = oe_n_q;
  assign dq_oe = dq_oe_q;
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 4,
  parameter int unsigned CLK_NS    = 4,
  parameter int unsigned T_AA_NS   = 12,
  parameter int unsigned T_AS_NS   = 0,
  parameter int unsigned T_WP_NS   = 9,
  parameter int unsigned T_DW_NS   = 6,
  parameter int unsigned T_WR_NS   = 0,
  parameter int unsigned T_OHZ_NS  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  localparam int unsigned AS_CYC  = phase_cycles(T_AS_NS, CLK_NS);
  localparam int unsigned WP_CYC  = max2(phase_cycles(T_WP_NS, CLK_NS),
                                         phase_cycles(T_DW_NS, CLK_NS));
  localparam int unsigned WR_CYC  = phase_cycles(T_WR_NS, CLK_NS);
  localparam int unsigned AA_CYC  = phase_cycles(T_AA_NS, CLK_NS);
  localparam int unsigned TA_CYC  = phase_cycles(T_OHZ_NS, CLK_NS);
  localparam int unsigned MAX_CYC = max2(max2(AS_CYC, WP_CYC),
                                         max2(max2(WR_CYC, AA_CYC), TA_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic              rst_sync_n;
  logic              ld, zero, accept, capture;
  logic [CNT_W-1:0]  ld_val;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rvalid_q;

  sram_ctl_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .ld     (ld),
    .ld_val (ld_val),
    .zero   (zero)
  );

  sram_ctl_fsm #(
    .CNT_W (CNT_W), .AS_CYC(AS_CYC), .WP_CYC(WP_CYC),
    .WR_CYC(WR_CYC), .AA_CYC(AA_CYC), .TA_CYC(TA_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .zero      (zero),
    .ld        (ld),
    .ld_val    (ld_val),
    .accept    (accept),
    .capture   (capture),
    .ready     (req_ready),
    .cs_n      (sram_cs_n),
    .we_n      (sram_we_n),
    .oe_n      (sram_oe_n),
    .dq_oe     (sram_dq_oe)
  );

  // request fields held for the whole operation
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  // read data taken at the last access cycle
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rdata_q <= '0;
    else if (capture) rdata_q <= sram_dq_in;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rvalid_q <= 1'b0;
    else             rvalid_q <= capture;
  end

  assign sram_addr   = addr_q;
  assign sram_dq_out = wdata_q;
  assign rsp_valid   = rvalid_q;
  assign rsp_rdata   = rdata_q;
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned WP_CYC = 3,
  parameter int unsigned AA_CYC = 3,
  parameter int unsigned TA_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              cs_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              dq_oe,
  input logic [ADDR_W-1:0] addr
);
  int unsigned we_len, oe_len, since_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_len   <= 0;
      oe_len   <= 0;
      since_oe <= TA_CYC;
    end else begin
      we_len   <= !we_n ? we_len + 1 : 0;
      oe_len   <= !oe_n ? oe_len + 1 : 0;
      if (!oe_n)                since_oe <= 0;
      else if (since_oe < TA_CYC) since_oe <= since_oe + 1;
    end
  end

  a_r1_idle_standby: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n && we_n && oe_n && !dq_oe));

  a_r2_we_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n && we_len != 0) |-> (we_len == WP_CYC));

  a_r3_cs_leads_we: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> ($past(!cs_n) && !cs_n));

  a_r3_cs_trails_we: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> !cs_n);

  a_r4_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);

  a_r5_drive_with_we: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe == !we_n);

  a_r6_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!cs_n && we_n));

  a_r6_oe_len: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n && oe_len != 0) |-> (oe_len == AA_CYC));

  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r7_valid_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (oe_n && $past(!oe_n)));

  a_r8_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (since_oe >= TA_CYC));

  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(addr));
endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W(ADDR_W), .WP_CYC(WP_CYC), .AA_CYC(AA_CYC), .TA_CYC(TA_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .cs_n      (sram_cs_n),
  .we_n      (sram_we_n),
  .oe_n      (sram_oe_n),
  .dq_oe     (sram_dq_oe),
  .addr      (sram_addr)
);

// File: tb/tb_sram_ctl.sv
`timescale 1ns/1ps
module tb_sram_ctl;
  localparam int AW = 5;
  localparam int DW = 4;
  localparam int CLK = 4, TAA = 12, TAS = 0, TWP = 9, TDW = 6, TWR = 0, TOHZ = 6;

  function automatic int cyc(input int lim);
    int c;
    c = (lim + CLK - 1) / CLK;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int AS_E = cyc(TAS);
  localparam int WP_E = (cyc(TWP) > cyc(TDW)) ? cyc(TWP) : cyc(TDW);
  localparam int WR_E = cyc(TWR);
  localparam int AA_E = cyc(TAA);
  localparam int TA_E = cyc(TOHZ);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [DW-1:0] rsp_rdata, sram_dq_out, sram_dq_in;
  logic [AW-1:0] sram_addr;

  int checks = 0, errors = 0;
  int conflicts = 0;
  int age = 0;
  logic [DW-1:0] mem [2**AW];
  logic [DW-1:0] shadow [2**AW];
  logic mem_drive;

  always #2 clk = ~clk;

  sram_ctl #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK), .T_AA_NS(TAA), .T_AS_NS(TAS),
    .T_WP_NS(TWP), .T_DW_NS(TDW), .T_WR_NS(TWR), .T_OHZ_NS(TOHZ)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_cs_n(sram_cs_n),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_addr(sram_addr),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  // behavioural memory: data is wrong until the access count has elapsed
  assign mem_drive = !sram_cs_n && !sram_oe_n && sram_we_n;
  always_comb begin
    if (mem_drive)       sram_dq_in = (age >= AA_E) ? mem[sram_addr] : ~mem[sram_addr];
    else if (sram_dq_oe) sram_dq_in = sram_dq_out;
    else                 sram_dq_in = '0;
  end

  always @(negedge clk) begin
    if (!sram_cs_n && !sram_we_n) mem[sram_addr] <= sram_dq_out;
    age <= mem_drive ? age + 1 : 0;
    if (mem_drive && sram_dq_oe) conflicts <= conflicts + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_op(input bit wr, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input bit noisy);
    int busy = 0, wel = 0, oel = 0, pre = 0, post = 0, rv = 0;
    int drv_bad = 0, addr_bad = 0;
    logic [DW-1:0] rd = '0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    if (noisy) begin
      req_addr = ~a; req_wdata = ~d; req_write = !wr;
    end else begin
      req_valid = 1'b0;
    end
    while (!req_ready && busy < 100) begin
      busy++;
      if (!sram_cs_n && sram_addr != a) addr_bad++;
      if (!sram_we_n) begin
        wel++;
        if (!sram_dq_oe || sram_dq_out != d) drv_bad++;
      end else if (sram_dq_oe) drv_bad++;
      if (!sram_oe_n) oel++;
      if (!sram_cs_n && sram_we_n && wel == 0) pre++;
      if (!sram_cs_n && sram_we_n && wel != 0) post++;
      if (rsp_valid) begin rv++; rd = rsp_rdata; end
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(addr_bad == 0, "R9 address held", addr_bad, 0);
    if (wr) begin
      shadow[a] = d;
      chk(wel == WP_E, "R2 write pulse cycles", wel, WP_E);
      chk(pre == AS_E, "R3 select before strobe", pre, AS_E);
      chk(post == WR_E, "R3 select after strobe", post, WR_E);
      chk(oel == 0, "R4 output enable in write", oel, 0);
      chk(drv_bad == 0, "R5 driver tracks strobe", drv_bad, 0);
      chk(rv == 0, "R7 no response on write", rv, 0);
      chk(busy == AS_E + WP_E + WR_E, "R10 write busy", busy, AS_E + WP_E + WR_E);
    end else begin
      chk(oel == AA_E, "R6 access cycles", oel, AA_E);
      chk(pre == AA_E, "R6 select during read", pre, AA_E);
      chk(wel == 0 && drv_bad == 0, "R5 no drive on read", drv_bad + wel, 0);
      chk(rv == 1, "R7 one valid pulse", rv, 1);
      chk(rd == shadow[a], "R7 read data", rd, shadow[a]);
      chk(busy == AA_E + TA_E, "R8 R10 read busy incl turnaround", busy, AA_E + TA_E);
    end
    // a held request must not have been taken during the operation
    chk(sram_cs_n && sram_we_n && sram_oe_n, "R9 held request ignored", sram_cs_n, 1);
  endtask

  initial begin
    for (int i = 0; i < 2**AW; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    chk(sram_cs_n && sram_we_n && sram_oe_n, "R1 strobes in reset", sram_cs_n, 1);
    chk(!sram_dq_oe && !rsp_valid, "R1 driver and valid in reset", sram_dq_oe, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);
    chk(sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe, "R1 idle standby",
        sram_cs_n, 1);
    // exhaustive write then read back
    for (int a = 0; a < 2**AW; a++)
      do_op(1'b1, AW'(a), DW'((a * 7 + 3) & 15), (a % 5) == 0);
    for (int a = 0; a < 2**AW; a++)
      do_op(1'b0, AW'(a), '0, (a % 4) == 1);
    // read immediately followed by write, extremes of data
    for (int a = 0; a < 2**AW; a += 3) begin
      do_op(1'b0, AW'(a), '0, 1'b0);
      do_op(1'b1, AW'(a), (a % 2) ? 4'hF : 4'h0, 1'b0);
      do_op(1'b0, AW'(a), '0, 1'b0);
    end
    repeat (2) @(negedge clk);
    chk(conflicts == 0, "R8 no bus overlap", conflicts, 0);
    chk(req_ready && !rsp_valid, "R1 idle at end", req_ready, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule